// File: doc/BRIEF.md
# Vertical Sync Window and Flywheel

This block turns a raw vertical pulse, which an upstream integrator recovers from composite video, into a clean vertical sync output `vs` and a field-identity bit `hb`. It measures time in half-lines. A strobe `hstb` arrives twice per line, and each strobe advances a position counter. The counter restarts at every vertical event. The expected field length P, in half-lines, comes from the control inputs.

In input-derived mode, a raw pulse can be gated through a window around the expected position. A missing pulse can be filled in at the expected position (flywheel). These two features are enabled independently. In free-running modes the raw input is ignored and the block makes a vertical event every P half-lines. Three period families are supported: interlaced (625/525), terminal (624/524) and a long non-standard period (688/576). Each event starts a `vs` pulse five half-lines long and updates `hb`.

Top module: `vsync_window`

## Requirements
- R1: A synchronous active-high `rst` clears `vs` and `hb` to 0 and sets the position counter and the half-line phase to 0. With all controls at 0 the block is input-derived, gated, wide-windowed, with P = 625 and no flywheel.
- R2: In input mode (`free_run`=0, `term`=0) with `nsup_off`=0, a raw rising edge is accepted only when the position lies within [P-W, P+W]. The position is the number of strobes since the last event. P is 625 for `sel60`=0 and 525 for `sel60`=1. Rejected edges produce no `vs` and leave `hb` unchanged.
- R3: `narrow`=1 sets W = 2 half-lines and `narrow`=0 sets W = 16 half-lines.
- R4: In input mode with `nsup_off`=1, every rising edge of `vraw` is accepted, wherever it falls.
- R5: In input mode with `flywheel`=1, if no edge is accepted before it, an event is inserted on the strobe that takes the position to P.
- R6: In input mode without flywheel, when the position passes P+W with no event, the counter realigns as if an event had occurred at P. This produces no `vs`, so the window stays on the expected phase.
- R7: With `free_run`=1, `term`=0 and `flywheel`=1, events occur every 625 (`sel60`=0) or 525 (`sel60`=1) strobes counted from reset, and `vraw` has no effect.
- R8: With `term`=1, events occur every 624 or 525-1=524 strobes, whatever `free_run` and `flywheel` are.
- R9: With `free_run`=1, `term`=0 and `flywheel`=0, events occur every 688 (`sel60`=0) or 576 (`sel60`=1) strobes.
- R10: `vs` rises on the clock after an event and falls on the fifth strobe after the event.
- R11: `hb` inverts at each event. The exception is an accepted raw edge that lies inside the window while the half-line phase is even (an even number of strobes since reset, the first half of a line): then `hb` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hstb | input | 1 | Half-line strobe, one clock wide |
| vraw | input | 1 | Raw vertical pulse from the integrator |
| free_run | input | 1 | Free-running vertical generation |
| term | input | 1 | Terminal free-running period (whole lines) |
| flywheel | input | 1 | Insert missing vertical events / selects the free period family |
| sel60 | input | 1 | 0: 50 Hz field lengths, 1: 60 Hz field lengths |
| nsup_off | input | 1 | 1 disables window gating |
| narrow | input | 1 | 1 selects the narrow window |
| vs | output | 1 | Cleaned vertical sync pulse |
| hb | output | 1 | Field identity bit |

## Verification
The hardest state to reach is a missed pulse in gated mode without flywheel. There the block must realign silently, so that a later pulse is accepted at the original expected phase and not at the position of the last pulse. The forced clear of `hb` is also hard to observe, because it only differs from a plain toggle when `hb` is already 0. The stimulus drives the strobe itself and places each raw pulse on an exact strobe count after the last event. This reaches a skipped field, an edge just outside and just inside each window width, and an even-phase edge arriving while `hb` is low. Each free-running period family is then run across several fields from reset.

// File: rtl/vsw_pkg.sv
`timescale 1ns/1ps
package vsw_pkg;
    localparam int CNT_W   = 10;
    localparam int LINES_50 = 312;
    localparam int LINES_60 = 262;
    localparam int LONG_50  = 344;
    localparam int LONG_60  = 288;

    typedef logic [CNT_W-1:0] hcnt_t;

    typedef struct packed {
        logic free_run;
        logic term;
        logic flywheel;
        logic sel60;
        logic nsup_off;
        logic narrow;
    } vsw_ctl_t;

    typedef struct packed {
        logic  free;    // events generated internally, raw ignored
        logic  fly;     // insert missing events in input mode
        logic  gate;    // window gating active
        hcnt_t period;  // field length in half-lines
        hcnt_t win;     // window half-width in half-lines
    } vsw_cfg_t;

    function automatic hcnt_t field_len(input vsw_ctl_t c);
        if (c.term)
            return hcnt_t'(2 * (c.sel60 ? LINES_60 : LINES_50));
        else if (c.free_run && !c.flywheel)
            return hcnt_t'(2 * (c.sel60 ? LONG_60 : LONG_50));
        else
            return hcnt_t'(2 * (c.sel60 ? LINES_60 : LINES_50) + 1);
    endfunction
endpackage

// File: rtl/vsw_mode_dec.sv
`timescale 1ns/1ps
module vsw_mode_dec
    import vsw_pkg::*;
#(
    parameter int W_NARROW = 2,
    parameter int W_WIDE   = 16
) (
    input  vsw_ctl_t ctl,
    output vsw_cfg_t cfg
);
    localparam hcnt_t WN = hcnt_t'(W_NARROW);
    localparam hcnt_t WW = hcnt_t'(W_WIDE);

    always_comb begin
        cfg.free   = ctl.free_run | ctl.term;
        cfg.fly    = ctl.flywheel & ~cfg.free;
        cfg.gate   = ~ctl.nsup_off & ~cfg.free;
        cfg.period = field_len(ctl);
        cfg.win    = ctl.narrow ? WN : WW;
    end
endmodule

// File: rtl/vsw_field_ctr.sv
`timescale 1ns/1ps
module vsw_field_ctr
    import vsw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hstb,
    input  logic     vraw,
    input  vsw_cfg_t cfg,
    output logic     ev_acc,
    output logic     ev_gen,
    output logic     in_win,
    output logic     first_half
);
    hcnt_t pos;
    logic  vraw_q;
    logic  hphase;
    logic  raw_edge;
    hcnt_t lo, hi;

    always_comb begin
        raw_edge   = vraw & ~vraw_q;
        lo         = cfg.period - cfg.win;
        hi         = cfg.period + cfg.win;
        in_win     = (pos >= lo) && (pos <= hi);
        ev_acc     = raw_edge & ~cfg.free & (~cfg.gate | in_win);
        ev_gen     = hstb & ~ev_acc & (cfg.free | cfg.fly)
                     & (pos >= cfg.period - 1'b1);
        first_half = ~hphase;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            vraw_q <= 1'b0;
            hphase <= 1'b0;
        end else begin
            vraw_q <= vraw;
            if (hstb)
                hphase <= ~hphase;
            if (ev_acc || ev_gen)
                pos <= '0;
            else if (hstb) begin
                if (!cfg.free && !cfg.fly && pos >= hi)
                    pos <= cfg.win + 1'b1;   // silent realignment, R6
                else
                    pos <= pos + 1'b1;
            end
        end
    end

    // R7: free-running never accepts the raw input
    a_r7_free_no_accept: assert property (@(posedge clk) disable iff (rst)
        cfg.free |-> !ev_acc);
endmodule

// File: rtl/vsw_pulse_gen.sv
`timescale 1ns/1ps
module vsw_pulse_gen #(
    parameter int VS_HALVES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic hstb,
    input  logic ev_acc,
    input  logic ev_gen,
    input  logic first_half,
    input  logic in_win,
    output logic vs,
    output logic hb
);
    localparam int VW = $clog2(VS_HALVES + 1);

    logic [VW-1:0] left;
    logic          ev_any;

    assign ev_any = ev_acc | ev_gen;
    assign vs     = (left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            hb   <= 1'b0;
        end else begin
            if (ev_any)
                left <= VW'(VS_HALVES);
            else if (hstb && left != '0)
                left <= left - 1'b1;
            if (ev_acc)
                hb <= (first_half && in_win) ? 1'b0 : ~hb;
            else if (ev_gen)
                hb <= ~hb;
        end
    end

    a_r10_vs_follows_event: assert property (@(posedge clk) disable iff (rst)
        ev_any |=> vs);
    a_r10_vs_ends_on_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(vs) |-> $past(hstb));
    a_r11_hb_only_on_event: assert property (@(posedge clk) disable iff (rst)
        !ev_any |=> $stable(hb));
endmodule

// File: rtl/vsync_window.sv
`timescale 1ns/1ps
module vsync_window
    import vsw_pkg::*;
#(
    parameter int W_NARROW  = 2,
    parameter int W_WIDE    = 16,
    parameter int VS_HALVES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic hstb,
    input  logic vraw,
    input  logic free_run,
    input  logic term,
    input  logic flywheel,
    input  logic sel60,
    input  logic nsup_off,
    input  logic narrow,
    output logic vs,
    output logic hb
);
    vsw_ctl_t ctl;
    vsw_cfg_t cfg;
    logic     ev_acc, ev_gen, in_win, first_half;

    always_comb begin
        ctl.free_run = free_run;
        ctl.term     = term;
        ctl.flywheel = flywheel;
        ctl.sel60    = sel60;
        ctl.nsup_off = nsup_off;
        ctl.narrow   = narrow;
    end

    vsw_mode_dec #(.W_NARROW(W_NARROW), .W_WIDE(W_WIDE)) u_dec (
        .ctl (ctl),
        .cfg (cfg)
    );

    vsw_field_ctr u_ctr (
        .clk        (clk),
        .rst        (rst),
        .hstb       (hstb),
        .vraw       (vraw),
        .cfg        (cfg),
        .ev_acc     (ev_acc),
        .ev_gen     (ev_gen),
        .in_win     (in_win),
        .first_half (first_half)
    );

    vsw_pulse_gen #(.VS_HALVES(VS_HALVES)) u_pulse (
        .clk        (clk),
        .rst        (rst),
        .hstb       (hstb),
        .ev_acc     (ev_acc),
        .ev_gen     (ev_gen),
        .first_half (first_half),
        .in_win     (in_win),
        .vs         (vs),
        .hb         (hb)
    );

    // R2: in gated mode a new VS only starts from an in-window position
    a_r2_gate_in_window: assert property (@(posedge clk) disable iff (rst)
        ($rose(vs) && cfg.gate) |-> $past(in_win));
    // R4: ungated input mode accepts every rising edge
    a_r4_accept_all: assert property (@(posedge clk) disable iff (rst)
        (!cfg.free && !cfg.gate && vraw && !$past(vraw)) |=> vs);
endmodule

// File: tb/test_vsync_window.sv
`timescale 1ns/1ps
module test_vsync_window;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hstb = 1'b0, vraw = 1'b0;
    logic free_run = 0, term = 0, flywheel = 0, sel60 = 0, nsup_off = 0, narrow = 0;
    logic vs, hb;

    always #4 clk = ~clk;   // 125 MHz

    vsync_window i_vsync_window (
        .clk(clk), .rst(rst), .hstb(hstb), .vraw(vraw),
        .free_run(free_run), .term(term), .flywheel(flywheel),
        .sel60(sel60), .nsup_off(nsup_off), .narrow(narrow),
        .vs(vs), .hb(hb)
    );

    int checks = 0, failures = 0;
    int cur_k = 0;
    int pulse_at[8];  int n_pulse;
    int exp_k[8];     int exp_hb[8];  int n_exp;
    int ev_k[16];     int ev_hb[16];  int ev_fall[16]; int n_ev, n_fall;
    logic mon_en = 1'b0, vs_prev = 1'b0;
    int cycles = 0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(posedge clk) begin
        #2;
        if (mon_en && !rst) begin
            if (vs && !vs_prev && n_ev < 16) begin
                ev_k[n_ev] = cur_k; ev_hb[n_ev] = int'(hb); n_ev++;
            end
            if (!vs && vs_prev && n_fall < 16) begin
                ev_fall[n_fall] = cur_k; n_fall++;
            end
            vs_prev = vs;
        end
    end

    function automatic bit is_pulse(input int k);
        for (int i = 0; i < n_pulse; i++) if (pulse_at[i] == k) return 1'b1;
        return 1'b0;
    endfunction

    task automatic run_case(input string req, input logic f, input logic t, input logic fw,
                            input logic s6, input logic vo, input logic nw, input int nhalf);
        @(negedge clk);
        rst = 1'b1; mon_en = 1'b0; hstb = 0; vraw = 0;
        free_run = f; term = t; flywheel = fw; sel60 = s6; nsup_off = vo; narrow = nw;
        repeat (3) @(negedge clk);
        check_eq("R1", "vs in reset", int'(vs), 0);
        check_eq("R1", "hb in reset", int'(hb), 0);
        n_ev = 0; n_fall = 0; vs_prev = 1'b0; cur_k = 0;
        rst = 1'b0; mon_en = 1'b1;
        for (int k = 1; k <= nhalf; k++) begin
            @(negedge clk); cur_k = k; hstb = 1'b1;
            @(negedge clk); hstb = 1'b0;
            @(negedge clk); if (is_pulse(k)) vraw = 1'b1;
            @(negedge clk); vraw = 1'b0;
        end
        mon_en = 1'b0;
        check_eq(req, "event count", n_ev, n_exp);
        for (int i = 0; i < n_exp && i < n_ev; i++) begin
            check_eq(req, "event half-line", ev_k[i], exp_k[i]);
            check_eq("R11", "hb after event", ev_hb[i], exp_hb[i]);
            if (i < n_fall)
                check_eq("R10", "vs fall half-line", ev_fall[i], exp_k[i] + 5);
        end
    endtask

    task automatic set_exp3(input int k0, input int h0, input int k1, input int h1,
                            input int k2, input int h2, input int n);
        exp_k[0] = k0; exp_hb[0] = h0; exp_k[1] = k1; exp_hb[1] = h1;
        exp_k[2] = k2; exp_hb[2] = h2; n_exp = n;
    endtask

    initial begin
        // R7: interlaced free run, 50 and 60
        n_pulse = 0; set_exp3(625, 1, 1250, 0, 1875, 1, 3);
        run_case("R7", 1, 0, 1, 0, 0, 0, 1885);
        n_pulse = 0; set_exp3(525, 1, 1050, 0, 0, 0, 2);
        run_case("R7", 1, 0, 1, 1, 0, 0, 1060);
        // R7: raw pulse ignored in free run
        n_pulse = 1; pulse_at[0] = 300; set_exp3(625, 1, 0, 0, 0, 0, 1);
        run_case("R7", 1, 0, 1, 0, 0, 0, 640);
        // R8: terminal periods, flags around it irrelevant
        n_pulse = 0; set_exp3(624, 1, 1248, 0, 0, 0, 2);
        run_case("R8", 1, 1, 1, 0, 0, 0, 1260);
        n_pulse = 0; set_exp3(524, 1, 1048, 0, 0, 0, 2);
        run_case("R8", 0, 1, 0, 1, 0, 0, 1060);
        // R9: long free periods
        n_pulse = 0; set_exp3(688, 1, 1376, 0, 0, 0, 2);
        run_case("R9", 1, 0, 0, 0, 0, 0, 1390);
        n_pulse = 0; set_exp3(576, 1, 1152, 0, 0, 0, 2);
        run_case("R9", 1, 0, 0, 1, 0, 0, 1160);
        // R2 R3 R6: narrow gate, early reject, missed field, realigned accept
        n_pulse = 5; pulse_at[0] = 620; pulse_at[1] = 625; pulse_at[2] = 1252;
        pulse_at[3] = 1552; pulse_at[4] = 1880;
        set_exp3(625, 1, 1252, 0, 2500, 0, 3); pulse_at[5] = 2500; n_pulse = 6;
        run_case("R6", 0, 0, 0, 0, 0, 1, 2510);
        // R3 R11: wide window, forced clear while hb low, realignment by 16
        n_pulse = 3; pulse_at[0] = 610; pulse_at[1] = 1210; pulse_at[2] = 1875;
        set_exp3(610, 0, 1875, 1, 0, 0, 2);
        run_case("R3", 0, 0, 0, 0, 0, 0, 1885);
        // R4: ungated accepts anywhere
        n_pulse = 2; pulse_at[0] = 100; pulse_at[1] = 400;
        set_exp3(100, 1, 400, 0, 0, 0, 2);
        run_case("R4", 0, 0, 0, 0, 1, 0, 410);
        // R5: flywheel with gating, one real pulse then insertions
        n_pulse = 1; pulse_at[0] = 624;
        set_exp3(624, 0, 1249, 1, 1874, 0, 3);
        run_case("R5", 0, 0, 1, 0, 0, 1, 1885);
        // R5 R4: flywheel without gating
        n_pulse = 2; pulse_at[0] = 200; pulse_at[1] = 925;
        exp_k[3] = 1550; exp_hb[3] = 0;
        set_exp3(200, 1, 825, 0, 925, 1, 4);
        run_case("R5", 0, 0, 1, 0, 1, 0, 1560);
        // R2: 60 Hz window, far pulse rejected after realignment
        n_pulse = 2; pulse_at[0] = 525; pulse_at[1] = 1150;
        set_exp3(525, 1, 0, 0, 0, 0, 1);
        run_case("R2", 0, 0, 0, 1, 0, 1, 1200);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule